// File: doc/BRIEF.md
# Mixed-Width Amplifier Control Register Bank

This block holds the control registers of an audio power amplifier. It sits behind a byte-wide serial slave whose line protocol has already been turned into framed transactions. A frame opens with a start pulse. Its first write byte selects a register. The write bytes after that carry data for that register, and a stop pulse closes the frame. Reads are byte requests over a valid/ready channel. Each answer comes back through a one-entry response slot, also valid/ready. Reads return bytes of the register that the most recent address byte selected.

Most registers are a single byte. Two of them are four bytes wide, and a wide register takes a new value only when a full burst of four data bytes has arrived inside one frame. Bytes travel most significant first in both directions. The bank also provides:
- a fixed identity register;
- a status register whose value is taken live from an input pin;
- reserved holes in the address space;
- a sticky error flag that reports malformed accesses.

The write byte channel never stalls (`wr_ready` is held high). A read request is accepted when the response slot is empty or is being emptied in the same cycle (`rd_req_ready = !rsp_valid || rsp_ready`). A response stays valid with unchanged data until it is taken.

Top module: `amp_ctrl_regs`

## Requirements
- R1: After a synchronous reset, each byte register holds its default and `err_flag` and `rsp_valid` are low. The defaults are 0x00=0x6C, 0x03=0xA0, 0x04=0x05, 0x05=0x60, 0x07=0xFF, 0x08..0x0D=0x30, 0x0E=0xB1, 0x10=0x02, 0x18=0x3F, 0x1A=0x18, 0x1B=0x82 and 0x1C=0x05. Every other implemented register, including both wide ones, resets to 0. Before any address byte, reads target address 0x00.
- R2: In a frame of the form start, address A, one data byte D, where A is a writable byte register in 0x00..0x1C, A takes D at the edge that accepts D. A later read of A returns D.
- R3: Addresses 0x20 and 0x25 are 32-bit registers. Their value changes only at the edge that accepts the fourth data byte of a frame, and the first data byte becomes bits 31:24. Reads return four bytes, bits 31:24 first.
- R4: If a start or stop arrives after one to three data bytes for a wide register, the wide register keeps its old value and `err_flag` is set.
- R5: Address 0x01 always reads 0x03. A data byte written to it has no effect and does not set the error flag.
- R6: Address 0x02 reads the value of `status_in` in the cycle the read request is accepted. A data byte written to it has no effect and no error.
- R7: Addresses 0x0F, 0x11..0x17 and 0x1D..0x1F, and every address above 0x1C other than 0x20 and 0x25, are unsupported. Reading one returns 0x00 and sets the error flag. Writing one changes nothing and sets the error flag.
- R8: Data bytes beyond a register's width in one frame are dropped and set the error flag. The address never advances on its own. Reads past a register's width return 0x00 and set the error flag.
- R9: The read byte index goes back to the most significant byte at every start pulse and every address byte. A new frame with no address byte therefore rereads the last selected register from its first byte.
- R10: `wr_ready` is always 1. `rd_req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady. `rsp_valid` rises only in the cycle after a read request.
- R11: Once set, `err_flag` stays high until reset.
- R12: A write byte received while no frame is open is dropped and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_start | input | 1 | Frame start pulse |
| frm_stop | input | 1 | Frame stop pulse |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte ready, always 1 |
| wr_data | input | 8 | Write byte (address first, then data) |
| rd_req_valid | input | 1 | Read byte request valid |
| rd_req_ready | output | 1 | Read byte request ready |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 8 | Read response byte |
| status_in | input | 8 | Live status value shown at address 0x02 |
| err_flag | output | 1 | Sticky access error |

## Verification
The bench targets wide bursts cut short by a stop, which a design committing byte by byte would expose as a half-updated register. It sends overlong frames, which reveal a design that auto-increments into the next register or fails to flag the excess. It also tries reserved and out-of-range addresses, where a careless decode returns stale data, and the identity and status registers, where a design might store written bytes. Finally, it holds back the response channel while requests wait and rereads after a restarted frame. These two catch a response overwritten under back-pressure and a read index that fails to rewind.

// File: rtl/acr_pkg.sv
package acr_pkg;

  typedef enum logic [2:0] {
    RK_PLAIN,
    RK_IDENT,
    RK_STATUS,
    RK_WIDE,
    RK_NONE
  } reg_kind_e;

  // Power-on value of each single-byte register slot
  function automatic logic [7:0] plain_reset_value(input int unsigned idx);
    case (idx)
      0:                  plain_reset_value = 8'h6C;
      3:                  plain_reset_value = 8'hA0;
      4, 28:              plain_reset_value = 8'h05;
      5:                  plain_reset_value = 8'h60;
      7:                  plain_reset_value = 8'hFF;
      8, 9, 10, 11, 12, 13: plain_reset_value = 8'h30;
      14:                 plain_reset_value = 8'hB1;
      16:                 plain_reset_value = 8'h02;
      24:                 plain_reset_value = 8'h3F;
      26:                 plain_reset_value = 8'h18;
      27:                 plain_reset_value = 8'h82;
      default:            plain_reset_value = 8'h00;
    endcase
  endfunction

  // Unbacked holes inside the single-byte window
  function automatic logic is_hole(input int unsigned idx);
    return (idx == 15) || (idx >= 17 && idx <= 23) || (idx >= 29 && idx <= 31);
  endfunction

endpackage

// File: rtl/acr_decode.sv
module acr_decode
  import acr_pkg::*;
#(
  parameter int                      PLAIN_TOP   = 28,
  parameter int                      IDENT_ADDR  = 1,
  parameter int                      STATUS_ADDR = 2,
  parameter int                      NUM_WIDE    = 2,
  parameter logic [NUM_WIDE*8-1:0]   WIDE_ADDRS  = 16'h2520,
  parameter int                      WSW         = 1
) (
  input  logic [7:0]     addr,
  output reg_kind_e      kind,
  output logic [WSW-1:0] wide_idx
);

  always_comb begin
    kind     = RK_NONE;
    wide_idx = '0;
    if (32'(addr) <= 32'(PLAIN_TOP)) begin
      if (32'(addr) == 32'(IDENT_ADDR))       kind = RK_IDENT;
      else if (32'(addr) == 32'(STATUS_ADDR)) kind = RK_STATUS;
      else if (!is_hole(32'(addr)))           kind = RK_PLAIN;
    end
    for (int i = 0; i < NUM_WIDE; i++) begin
      if (addr == WIDE_ADDRS[i*8 +: 8]) begin
        kind     = RK_WIDE;
        wide_idx = WSW'(i);
      end
    end
  end

endmodule

// File: rtl/acr_plain.sv
module acr_plain
  import acr_pkg::*;
#(
  parameter  int PLAIN_TOP   = 28,
  parameter  int IDENT_ADDR  = 1,
  parameter  int STATUS_ADDR = 2,
  localparam int IW          = $clog2(PLAIN_TOP + 1),
  localparam int SLOTS       = 1 << IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      widx,
  input  logic [7:0]         wdata,
  output logic [SLOTS*8-1:0] q
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i > PLAIN_TOP || i == IDENT_ADDR || i == STATUS_ADDR || is_hole(i)) begin : g_tie
      assign q[i*8 +: 8] = 8'h00;
    end else begin : g_reg
      logic [7:0] val;
      always_ff @(posedge clk) begin
        if (rst)                             val <= plain_reset_value(i);
        else if (we && widx == IW'(i))       val <= wdata;
      end
      assign q[i*8 +: 8] = val;
    end
  end

endmodule

// File: rtl/acr_wide.sv
module acr_wide #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] d,
  output logic [WW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/acr_ctl.sv
module acr_ctl
  import acr_pkg::*;
#(
  parameter  int         WB          = 4,
  parameter  int         IW          = 5,
  parameter  int         NUM_WIDE    = 2,
  parameter  int         WSW         = 1,
  parameter  logic [7:0] IDENT_VALUE = 8'h03,
  localparam int         WW          = WB * 8,
  localparam int         SLOTS       = 1 << IW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frm_start,
  input  logic                  frm_stop,
  input  logic                  wr_valid,
  input  logic [7:0]            wr_data,
  input  logic                  rd_req_valid,
  output logic                  rd_req_ready,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_data,
  input  logic [7:0]            status_in,
  output logic                  err_flag,
  output logic [7:0]            addr_q,
  input  reg_kind_e             kind,
  input  logic [WSW-1:0]        wide_idx,
  input  logic [SLOTS*8-1:0]    plain_q,
  output logic                  plain_we,
  output logic                  wide_load,
  output logic [WW-1:0]         wide_d,
  input  logic [NUM_WIDE*WW-1:0] wide_q
);

  localparam int             CW       = $clog2(WB + 1);
  localparam logic [CW-1:0]  CNT_LAST = CW'(WB - 1);
  localparam logic [CW-1:0]  CNT_SAT  = CW'(WB);

  typedef enum logic [1:0] {FR_IDLE, FR_ADDR, FR_DATA} frame_e;

  frame_e         st;
  logic [CW-1:0]  dcnt;
  logic [CW-1:0]  ridx;
  logic [WW-9:0]  stage;
  logic [WW-1:0]  shifted;
  logic [WW-1:0]  wsel;
  logic [7:0]     rd_byte;
  logic           edge_evt, byte_evt, rd_fire, in_data, partial;
  logic           byte_err, rd_err, abort_err;

  assign edge_evt     = frm_start | frm_stop;
  assign byte_evt     = wr_valid & ~edge_evt;
  assign rd_req_ready = ~rsp_valid | rsp_ready;
  assign rd_fire      = rd_req_valid & rd_req_ready;
  assign in_data      = (st == FR_DATA);
  assign partial      = in_data && kind == RK_WIDE && dcnt != '0 && dcnt != CNT_SAT;
  assign shifted      = {stage, wr_data};
  assign wide_d       = shifted;

  assign plain_we  = byte_evt && in_data && kind == RK_PLAIN && dcnt == '0;
  assign wide_load = byte_evt && in_data && kind == RK_WIDE && dcnt == CNT_LAST;

  assign byte_err  = byte_evt && (st == FR_IDLE ||
                     (in_data && (kind == RK_NONE ||
                      ((kind == RK_WIDE) ? (dcnt == CNT_SAT) : (dcnt != '0)))));
  assign abort_err = edge_evt && partial;
  assign rd_err    = rd_fire && (kind == RK_NONE ||
                     ((kind == RK_WIDE) ? (ridx == CNT_SAT) : (ridx != '0)));

  // Byte that a read accepted this cycle returns
  always_comb begin
    wsel    = wide_q[wide_idx*WW +: WW];
    rd_byte = 8'h00;
    case (kind)
      RK_PLAIN:  if (ridx == '0) rd_byte = plain_q[addr_q[IW-1:0]*8 +: 8];
      RK_IDENT:  if (ridx == '0) rd_byte = IDENT_VALUE;
      RK_STATUS: if (ridx == '0) rd_byte = status_in;
      RK_WIDE: begin
        for (int b = 0; b < WB; b++) begin
          if (ridx == CW'(b)) rd_byte = wsel[(WB-1-b)*8 +: 8];
        end
      end
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_IDLE;
      addr_q    <= 8'h00;
      dcnt      <= '0;
      ridx      <= '0;
      stage     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
      err_flag  <= 1'b0;
    end else begin
      if (byte_err || rd_err || abort_err) err_flag <= 1'b1;

      if (frm_start) begin
        st   <= FR_ADDR;
        dcnt <= '0;
      end else if (frm_stop) begin
        st   <= FR_IDLE;
        dcnt <= '0;
      end else if (wr_valid) begin
        if (st == FR_ADDR) begin
          addr_q <= wr_data;
          st     <= FR_DATA;
          dcnt   <= '0;
        end else if (st == FR_DATA) begin
          if (dcnt != CNT_SAT) dcnt <= dcnt + CW'(1);
          if (kind == RK_WIDE) stage <= shifted[WW-9:0];
        end
      end

      if (frm_start || (byte_evt && st == FR_ADDR)) ridx <= '0;
      else if (rd_fire && ridx != CNT_SAT)          ridx <= ridx + CW'(1);

      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_RSP_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(rd_req_valid)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R11
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    edge_evt && partial |=> err_flag); // R4
  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (rst)
    rd_fire && kind == RK_IDENT && ridx == '0 |=> rsp_data == IDENT_VALUE); // R5

endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
  import acr_pkg::*;
#(
  parameter int                    PLAIN_TOP   = 28,
  parameter int                    IDENT_ADDR  = 1,
  parameter logic [7:0]            IDENT_VALUE = 8'h03,
  parameter int                    STATUS_ADDR = 2,
  parameter int                    NUM_WIDE    = 2,
  parameter logic [NUM_WIDE*8-1:0] WIDE_ADDRS  = 16'h2520,
  parameter int                    WIDE_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frm_start,
  input  logic       frm_stop,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       rd_req_valid,
  output logic       rd_req_ready,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  input  logic [7:0] status_in,
  output logic       err_flag
);

  localparam int IW    = $clog2(PLAIN_TOP + 1);
  localparam int SLOTS = 1 << IW;
  localparam int WW    = WIDE_BYTES * 8;
  localparam int WSW   = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;

  logic [7:0]             addr_q;
  reg_kind_e              kind;
  logic [WSW-1:0]         wide_idx;
  logic [SLOTS*8-1:0]     plain_q;
  logic                   plain_we;
  logic                   wide_load;
  logic [WW-1:0]          wide_d;
  logic [NUM_WIDE*WW-1:0] wide_q;

  assign wr_ready = 1'b1;

  acr_decode #(
    .PLAIN_TOP(PLAIN_TOP), .IDENT_ADDR(IDENT_ADDR), .STATUS_ADDR(STATUS_ADDR),
    .NUM_WIDE(NUM_WIDE), .WIDE_ADDRS(WIDE_ADDRS), .WSW(WSW)
  ) u_decode (
    .addr(addr_q), .kind(kind), .wide_idx(wide_idx)
  );

  acr_plain #(
    .PLAIN_TOP(PLAIN_TOP), .IDENT_ADDR(IDENT_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_plain (
    .clk(clk), .rst(rst), .we(plain_we), .widx(addr_q[IW-1:0]),
    .wdata(wr_data), .q(plain_q)
  );

  for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
    acr_wide #(.WW(WW)) u_wide (
      .clk(clk), .rst(rst), .load(wide_load && wide_idx == WSW'(i)),
      .d(wide_d), .q(wide_q[i*WW +: WW])
    );
  end

  acr_ctl #(
    .WB(WIDE_BYTES), .IW(IW), .NUM_WIDE(NUM_WIDE), .WSW(WSW), .IDENT_VALUE(IDENT_VALUE)
  ) u_ctl (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .status_in(status_in), .err_flag(err_flag),
    .addr_q(addr_q), .kind(kind), .wide_idx(wide_idx), .plain_q(plain_q),
    .plain_we(plain_we), .wide_load(wide_load), .wide_d(wide_d), .wide_q(wide_q)
  );

  AST_WIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$stable(wide_q) |-> $past(wr_valid)); // R3
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> !err_flag && !rsp_valid); // R1

endmodule

// File: tb/amp_ctrl_regs_bench.sv
module amp_ctrl_regs_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_start = 1'b0, frm_stop = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req_valid = 1'b0;
  logic       rd_req_ready;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [7:0] status_in = 8'h00;
  logic       err_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  amp_ctrl_regs u_amp_ctrl_regs (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .status_in(status_in), .err_flag(err_flag)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_byte  [0:255];
  logic [31:0] m_long  [0:255];
  bit          m_wrote [0:255];
  logic [7:0]  m_q[$];
  int          m_state, m_addr, m_cnt, m_ridx;
  bit          m_rep, m_rv, m_err;
  logic [7:0]  m_rd;
  string       m_rt;

  // 0 byte reg, 1 identity, 2 status, 3 wide, 4 unsupported
  function automatic int kind_of(input int a);
    if (a == 1) return 1;
    if (a == 2) return 2;
    if (a == 32 || a == 37) return 3;
    if (a <= 28 && a != 15 && !(a >= 17 && a <= 23)) return 0;
    return 4;
  endfunction

  function automatic logic [7:0] boot_val(input int a);
    if (a >= 8 && a <= 13) return 8'h30;
    case (a)
      28, 4: return 8'h05;
      27: return 8'h82;
      26: return 8'h18;
      24: return 8'h3F;
      16: return 8'h02;
      14: return 8'hB1;
      7:  return 8'hFF;
      5:  return 8'h60;
      3:  return 8'hA0;
      0:  return 8'h6C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit fire, eset;
    logic [7:0] rb;
    string rt, et;
    int k;
    fire = rd_req_valid && (!m_rv || rsp_ready);
    eset = 0;
    et = "R11";
    rb = 8'h00;
    rt = "";
    if (rst) begin
      for (int a = 0; a < 256; a++) begin
        m_byte[a] = boot_val(a); m_long[a] = 32'h0; m_wrote[a] = 0;
      end
      m_q.delete();
      m_state = 0; m_addr = 0; m_cnt = 0; m_ridx = 0;
      m_rep = 0; m_rv = 0; m_err = 0; m_rd = 8'h00; m_rt = "R1";
      et = "R1";
    end else begin
      if (fire) begin
        k = kind_of(m_addr);
        case (k)
          0: begin rt = m_wrote[m_addr] ? "R2" : "R1";
                   if (m_ridx == 0) rb = m_byte[m_addr]; else begin eset = 1; et = "R8"; end end
          1: begin rt = "R5"; if (m_ridx == 0) rb = 8'h03; else begin eset = 1; et = "R8"; end end
          2: begin rt = "R6"; if (m_ridx == 0) rb = status_in; else begin eset = 1; et = "R8"; end end
          3: begin rt = "R3"; if (m_ridx < 4) rb = m_long[m_addr][8*(3-m_ridx) +: 8];
                   else begin eset = 1; et = "R8"; end end
          default: begin rt = "R7"; eset = 1; et = "R7"; end
        endcase
        if (m_rep) rt = "R9";
        m_ridx++;
      end
      if (frm_start || frm_stop) begin
        if (m_state == 2 && kind_of(m_addr) == 3 && m_q.size() > 0 && m_q.size() < 4) begin
          eset = 1; et = "R4";
        end
        m_q.delete();
        m_cnt = 0;
        if (frm_start) begin m_state = 1; m_ridx = 0; m_rep = 1; end
        else m_state = 0;
      end else if (wr_valid) begin
        if (m_state == 0) begin eset = 1; et = "R12"; end
        else if (m_state == 1) begin
          m_addr = wr_data; m_state = 2; m_cnt = 0; m_ridx = 0; m_rep = 0; m_q.delete();
        end else begin
          k = kind_of(m_addr);
          case (k)
            0: if (m_cnt == 0) begin m_byte[m_addr] = wr_data; m_wrote[m_addr] = 1; end
               else begin eset = 1; et = "R8"; end
            1, 2: if (m_cnt != 0) begin eset = 1; et = "R8"; end
            3: if (m_cnt < 4) begin
                 m_q.push_back(wr_data);
                 if (m_q.size() == 4) m_long[m_addr] = {m_q[0], m_q[1], m_q[2], m_q[3]};
               end else begin eset = 1; et = "R8"; end
            default: begin eset = 1; et = "R7"; end
          endcase
          m_cnt++;
        end
      end
      if (fire) begin m_rv = 1; m_rd = rb; m_rt = rt; end
      else if (rsp_ready) m_rv = 0;
      if (eset) m_err = 1;
    end
    #1;
    cmp(wr_ready === 1'b1, "R10", "wr_ready", int'(wr_ready), 1);
    cmp(rd_req_ready === (!m_rv || rsp_ready), "R10", "rd_req_ready",
        int'(rd_req_ready), int'(!m_rv || rsp_ready));
    cmp(rsp_valid === m_rv, "R10", "rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv) cmp(rsp_data === m_rd, m_rt, "rsp_data", int'(rsp_data), int'(m_rd));
    cmp(err_flag === m_err, et, "err_flag", int'(err_flag), int'(m_err));
  end

  // ---------------- stimulus helpers (enter and leave at negedge) ----------------
  task automatic step(); @(negedge clk); endtask
  task automatic go_start(); frm_start = 1; step(); frm_start = 0; endtask
  task automatic go_stop();  frm_stop = 1;  step(); frm_stop = 0;  endtask
  task automatic put(input logic [7:0] b); wr_valid = 1; wr_data = b; step(); wr_valid = 0; endtask
  task automatic point(input logic [7:0] a); go_start(); put(a); go_stop(); endtask
  task automatic wr1(input logic [7:0] a, input logic [7:0] d); go_start(); put(a); put(d); go_stop(); endtask
  task automatic wr4(input logic [7:0] a, input logic [31:0] d);
    go_start(); put(a);
    for (int i = 3; i >= 0; i--) put(d[8*i +: 8]);
    go_stop();
  endtask
  task automatic rd();
    bit ok;
    rd_req_valid = 1;
    while (1) begin
      #1 ok = rd_req_ready;
      step();
      if (ok) break;
    end
    rd_req_valid = 0;
  endtask
  task automatic rd_n(input int n); for (int i = 0; i < n; i++) rd(); endtask
  task automatic do_reset(); rst = 1; repeat (3) step(); rst = 0; step(); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired R10 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();
    // R1: explicit reset state
    cmp(err_flag === 1'b0, "R1", "err after reset", int'(err_flag), 0);
    cmp(rsp_valid === 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    rd();                                   // R1: pointer defaults to 0x00
    for (int a = 0; a <= 28; a++) begin
      if (kind_of(a) == 4) continue;
      point(8'(a)); rd();
    end
    point(8'h20); rd_n(4);
    point(8'h25); rd_n(4);
    cmp(err_flag === 1'b0, "R1", "no error from clean reads", int'(err_flag), 0);

    // R2: byte register writes
    wr1(8'h07, 8'h5A); wr1(8'h1C, 8'hC3); wr1(8'h00, 8'h11);
    point(8'h07); rd(); point(8'h1C); rd(); point(8'h00); rd();
    // R5: identity register ignores writes
    wr1(8'h01, 8'h77); point(8'h01); rd();
    cmp(err_flag === 1'b0, "R5", "identity write no error", int'(err_flag), 0);
    // R6: live status
    status_in = 8'h9E; point(8'h02); rd();
    wr1(8'h02, 8'h11); status_in = 8'h44; point(8'h02); rd();

    // R3: wide registers, MSB first
    wr4(8'h20, 32'h11223344); point(8'h20); rd_n(4);
    wr4(8'h25, 32'hA5C3_0F81); point(8'h25); rd_n(4);
    // R9: new frame without address rereads from MSB
    go_start(); rd_n(2); go_start(); rd_n(4); go_stop();
    // R4: burst cut short by stop
    go_start(); put(8'h25); put(8'hDE); put(8'hAD); put(8'hBE); go_stop();
    point(8'h25); rd_n(4);
    cmp(err_flag === 1'b1, "R4", "partial burst flagged", int'(err_flag), 1);
    repeat (5) step();                      // R11: flag stays up
    do_reset();

    // R4: burst cut short by a restart
    go_start(); put(8'h20); put(8'h01); go_start(); put(8'h20); go_stop();
    rd_n(4);
    do_reset();
    // R8: extra data bytes, no auto-increment
    go_start(); put(8'h05); put(8'h21); put(8'h22); put(8'h23); go_stop();
    point(8'h05); rd(); point(8'h06); rd();
    do_reset();
    // R8: wide overlong and reads past width
    go_start(); put(8'h20); for (int i = 0; i < 6; i++) put(8'(8'h40 + i)); go_stop();
    point(8'h20); rd_n(6);
    do_reset();
    point(8'h03); rd_n(2);
    do_reset();
    // R7: unsupported addresses
    wr1(8'h0F, 8'h99); point(8'h10); rd(); point(8'h0F); rd();
    do_reset();
    point(8'h30); rd();
    do_reset();
    wr1(8'hFF, 8'h12); point(8'h1D); rd();
    do_reset();
    // R12: byte outside any frame
    put(8'h07); point(8'h07); rd();
    do_reset();

    // R10: back-pressure on the response slot
    wr4(8'h25, 32'h0102_0304);
    point(8'h25);
    rsp_ready = 0;
    fork
      begin rd_n(4); end
      begin repeat (6) step(); rsp_ready = 1; step(); rsp_ready = 0; repeat (3) step(); rsp_ready = 1; end
    join
    rsp_ready = 1;
    repeat (4) step();
    cmp(rsp_valid === 1'b0, "R10", "slot drained", int'(rsp_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule